// File: doc/BRIEF.md
# Pulse-Swallow Programmable Feedback Divider

This block divides a fast input clock by a programmable integer N = P·B + A. It models a dual-modulus prescaler as plain logic in the same clock domain. The prescaler divides by P or by P+1. A 13-bit main counter and a 5-bit swallow counter, both advanced once per prescaler cycle, decide which modulus applies. In every output period the first A prescaler cycles run at P+1 and the remaining B−A cycles run at P. This yields any integer N in the continuous range without a single wide binary counter.

The modulus select, the main count B and the swallow count A are static inputs, sampled only at the end of an output period. If a setting is illegal, an error flag rises and the divider keeps its last accepted setting. The output is a pulse one clock wide, issued once per period.

Top module: `swallow_divider`

## Requirements
- R1: `div_pulse` rises exactly once every N = P·B + A input clocks, with P chosen by `mod_sel` as 00→8, 01→16, 10→32.
- R2: Within one output period the swallow count remaining never exceeds the main count remaining, so exactly A of the B prescaler cycles use modulus P+1.
- R3: `div_pulse` is high for exactly one clock per period.
- R4: While `rst_n` is low both outputs are low. After release the default setting applies (`mod_sel`=00, B=7, A=0), and the first pulse appears 56 clocks after the release.
- R5: A setting is legal when `mod_sel`≠11, A≤P−1, B≥A and B≥1. The edge cases B=A and A=P−1 are accepted.
- R6: `cfg_err` is high one clock after the inputs hold an illegal setting, and low one clock after they hold a legal one.
- R7: A change to `mod_sel`, B or A takes effect only at the next period end. The period in progress completes with the old value.
- R8: An illegal setting present at a period end leaves the previous accepted setting in force.
- R9: The minimum continuous ratio P·(P−1) is reachable for each modulus: 56, 240 and 992.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Active-low synchronous reset |
| mod_sel | input | 2 | Prescaler modulus select (00: 8/9, 01: 16/17, 10: 32/33, 11: illegal) |
| b_cnt | input | 13 | Main counter value B |
| a_cnt | input | 5 | Swallow counter value A |
| div_pulse | output | 1 | One-clock pulse per divided period |
| cfg_err | output | 1 | Current inputs form an illegal setting |

## Verification
The checker assumes that the divide inputs are static relative to the output period, or that they change only between clock edges. It also assumes that every period is at least eight clocks long, which the legality rule guarantees because B≥1 and P≥8. The stimulus drives the inputs on the falling edge. It changes them either right after a pulse or at a chosen offset inside a period, and it checks each illegal setting only against the last accepted one. All ratios are kept small enough that every vector completes two full periods within the run.

// File: rtl/swdiv_pkg.sv
package swdiv_pkg;

    localparam int MAIN_W = 13;
    localparam int SWAL_W = 5;
    localparam int PRE_W  = SWAL_W + 1;

    typedef enum logic [1:0] {
        MOD_8   = 2'b00,
        MOD_16  = 2'b01,
        MOD_32  = 2'b10,
        MOD_BAD = 2'b11
    } mod_sel_e;

    typedef struct packed {
        logic [PRE_W-1:0]  pval;
        logic [MAIN_W-1:0] bcnt;
        logic [SWAL_W-1:0] acnt;
    } div_cfg_t;

    function automatic logic [PRE_W-1:0] mod_to_p(input logic [1:0] sel);
        case (sel)
            MOD_8:   return PRE_W'(8);
            MOD_16:  return PRE_W'(16);
            MOD_32:  return PRE_W'(32);
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/swdiv_cfg_hold.sv
module swdiv_cfg_hold
    import swdiv_pkg::*;
#(
    parameter logic [PRE_W-1:0]  DEF_P = PRE_W'(8),
    parameter logic [MAIN_W-1:0] DEF_B = MAIN_W'(7),
    parameter logic [SWAL_W-1:0] DEF_A = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mod_sel,
    input  logic [MAIN_W-1:0] b_in,
    input  logic [SWAL_W-1:0] a_in,
    input  logic              load,
    output div_cfg_t          act_cfg,
    output div_cfg_t          next_cfg,
    output logic              cfg_err
);

    typedef struct packed {
        div_cfg_t act;
        logic     err;
    } hold_st_t;

    hold_st_t st_d, st_q;
    logic [PRE_W-1:0] p_in;
    logic             legal;
    div_cfg_t         cand;

    always_comb begin
        p_in  = mod_to_p(mod_sel);
        legal = (mod_sel != MOD_BAD)
              && ({1'b0, a_in} < p_in)
              && (b_in >= MAIN_W'(a_in))
              && (b_in != '0);
        cand.pval = p_in;
        cand.bcnt = b_in;
        cand.acnt = a_in;
        next_cfg  = legal ? cand : st_q.act;
        st_d      = st_q;
        st_d.err  = !legal;
        if (load) begin
            st_d.act = next_cfg;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.act.pval <= DEF_P;
            st_q.act.bcnt <= DEF_B;
            st_q.act.acnt <= DEF_A;
            st_q.err      <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign act_cfg = st_q.act;
    assign cfg_err = st_q.err;

endmodule

// File: rtl/swdiv_prescaler.sv
module swdiv_prescaler
    import swdiv_pkg::*;
#(
    parameter logic [PRE_W-1:0] INIT_LEN = PRE_W'(8)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PRE_W-1:0] next_len,
    output logic             tick
);

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_st_t;

    pre_st_t st_d, st_q;

    always_comb begin
        tick   = (st_q.cnt == '0);
        st_d   = st_q;
        if (tick) begin
            st_d.cnt = next_len - 1'b1;
        end else begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt <= INIT_LEN - 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/swdiv_counters.sv
module swdiv_counters
    import swdiv_pkg::*;
#(
    parameter logic [MAIN_W-1:0] INIT_B = MAIN_W'(7),
    parameter logic [SWAL_W-1:0] INIT_A = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [PRE_W-1:0]  act_p,
    input  div_cfg_t          next_cfg,
    output logic [PRE_W-1:0]  next_len,
    output logic              period_end,
    output logic [MAIN_W-1:0] main_left,
    output logic [SWAL_W-1:0] swal_left
);

    typedef struct packed {
        logic [MAIN_W-1:0] mn;
        logic [SWAL_W-1:0] sw;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic [SWAL_W-1:0] sw_after;
    logic              last_cyc;

    always_comb begin
        last_cyc   = (st_q.mn == MAIN_W'(1));
        period_end = tick && last_cyc;
        sw_after   = (st_q.sw != '0) ? (st_q.sw - 1'b1) : '0;
        if (last_cyc) begin
            next_len = next_cfg.pval + PRE_W'(next_cfg.acnt != '0);
        end else begin
            next_len = act_p + PRE_W'(sw_after != '0);
        end
        st_d = st_q;
        if (tick) begin
            if (last_cyc) begin
                st_d.mn = next_cfg.bcnt;
                st_d.sw = next_cfg.acnt;
            end else begin
                st_d.mn = st_q.mn - 1'b1;
                st_d.sw = sw_after;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mn <= INIT_B;
            st_q.sw <= INIT_A;
        end else begin
            st_q <= st_d;
        end
    end

    assign main_left = st_q.mn;
    assign swal_left = st_q.sw;

endmodule

// File: rtl/swallow_divider.sv
module swallow_divider
    import swdiv_pkg::*;
#(
    parameter logic [1:0] DEF_SEL = 2'b00,
    parameter int         DEF_B   = 7,
    parameter int         DEF_A   = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mod_sel,
    input  logic [MAIN_W-1:0] b_cnt,
    input  logic [SWAL_W-1:0] a_cnt,
    output logic              div_pulse,
    output logic              cfg_err
);

    localparam logic [PRE_W-1:0]  DEF_P    = mod_to_p(DEF_SEL);
    localparam logic [MAIN_W-1:0] INIT_B   = MAIN_W'(DEF_B);
    localparam logic [SWAL_W-1:0] INIT_A   = SWAL_W'(DEF_A);
    localparam logic [PRE_W-1:0]  INIT_LEN = DEF_P + PRE_W'(DEF_A != 0);

    typedef struct packed {
        logic pulse;
    } top_st_t;

    top_st_t           st_d, st_q;
    div_cfg_t          act_cfg, next_cfg;
    logic              pre_tick, period_end;
    logic [PRE_W-1:0]  next_len;
    logic [MAIN_W-1:0] main_left;
    logic [SWAL_W-1:0] swal_left;

    swdiv_cfg_hold #(
        .DEF_P (DEF_P),
        .DEF_B (INIT_B),
        .DEF_A (INIT_A)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .mod_sel  (mod_sel),
        .b_in     (b_cnt),
        .a_in     (a_cnt),
        .load     (period_end),
        .act_cfg  (act_cfg),
        .next_cfg (next_cfg),
        .cfg_err  (cfg_err)
    );

    swdiv_prescaler #(
        .INIT_LEN (INIT_LEN)
    ) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .next_len (next_len),
        .tick     (pre_tick)
    );

    swdiv_counters #(
        .INIT_B (INIT_B),
        .INIT_A (INIT_A)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (pre_tick),
        .act_p      (act_cfg.pval),
        .next_cfg   (next_cfg),
        .next_len   (next_len),
        .period_end (period_end),
        .main_left  (main_left),
        .swal_left  (swal_left)
    );

    always_comb begin
        st_d       = st_q;
        st_d.pulse = period_end;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pulse <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign div_pulse = st_q.pulse;

endmodule

// File: rtl/swdiv_checker.sv
module swdiv_checker
    import swdiv_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        mod_sel,
    input logic              div_pulse,
    input logic              cfg_err,
    input logic              period_end,
    input div_cfg_t          act_cfg,
    input logic [MAIN_W-1:0] main_left,
    input logic [SWAL_W-1:0] swal_left
);

    AST_PULSE_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |=> !div_pulse); // R3

    AST_BAD_SEL_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_sel == MOD_BAD) |=> cfg_err); // R6

    AST_ACTIVE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, act_cfg.acnt} < act_cfg.pval)
        && (act_cfg.bcnt >= MAIN_W'(act_cfg.acnt))
        && (act_cfg.bcnt != '0)); // R5

    AST_CFG_HELD_MIDPERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        !period_end |=> $stable(act_cfg)); // R7

    AST_SWALLOW_WITHIN_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
        MAIN_W'(swal_left) <= main_left); // R2

    AST_MAIN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        main_left != '0); // R1

endmodule

bind swallow_divider swdiv_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mod_sel    (mod_sel),
    .div_pulse  (div_pulse),
    .cfg_err    (cfg_err),
    .period_end (period_end),
    .act_cfg    (act_cfg),
    .main_left  (main_left),
    .swal_left  (swal_left)
);

// File: tb/tb_swallow_divider.sv
`timescale 1ns/1ps
module tb_swallow_divider;

    typedef struct packed {
        logic [1:0]  sel;
        logic [12:0] b;
        logic [4:0]  a;
        logic [31:0] n;
        logic        err;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 13'd7,   5'd0,  32'd56,   1'b0},  // R9
        '{2'd0, 13'd9,   5'd5,  32'd77,   1'b0},  // R1 R2
        '{2'd0, 13'd9,   5'd7,  32'd79,   1'b0},  // R5 A=P-1
        '{2'd0, 13'd1,   5'd1,  32'd9,    1'b0},  // R5 B=A
        '{2'd1, 13'd15,  5'd0,  32'd240,  1'b0},  // R9
        '{2'd1, 13'd16,  5'd15, 32'd271,  1'b0},  // R1
        '{2'd2, 13'd31,  5'd0,  32'd992,  1'b0},  // R9
        '{2'd2, 13'd33,  5'd31, 32'd1087, 1'b0},  // R1
        '{2'd3, 13'd5,   5'd0,  32'd1087, 1'b1},  // R8 bad select
        '{2'd0, 13'd20,  5'd8,  32'd1087, 1'b1},  // R8 A>P-1
        '{2'd1, 13'd3,   5'd5,  32'd1087, 1'b1},  // R8 B<A
        '{2'd0, 13'd0,   5'd0,  32'd1087, 1'b1},  // R8 B=0
        '{2'd2, 13'd300, 5'd17, 32'd9617, 1'b0},  // R1
        '{2'd1, 13'd1,   5'd0,  32'd16,   1'b0}   // R5 smallest
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mod_sel = 2'd0;
    logic [12:0] b_cnt = 13'd7;
    logic [4:0]  a_cnt = 5'd0;
    logic        div_pulse, cfg_err;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    swallow_divider dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mod_sel   (mod_sel),
        .b_cnt     (b_cnt),
        .a_cnt     (a_cnt),
        .div_pulse (div_pulse),
        .cfg_err   (cfg_err)
    );

    function automatic string vec_tag(input int i);
        case (i)
            0, 4, 6:        return "R9";
            1:              return "R1/R2";
            2, 3, 13:       return "R5";
            8, 9, 10, 11:   return "R8";
            default:        return "R1";
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_pulse();
        while (div_pulse !== 1'b1) @(negedge clk);
    endtask

    // Called on a negedge where div_pulse is high; returns clocks to next pulse.
    task automatic measure(output int cnt);
        cnt = 0;
        @(negedge clk);
        cnt++;
        chk("R3", {31'd0, div_pulse}, 32'd0);
        while (div_pulse !== 1'b1) begin
            @(negedge clk);
            cnt++;
        end
    endtask

    task automatic apply(input logic [1:0] s, input logic [12:0] b, input logic [4:0] a);
        mod_sel = s;
        b_cnt   = b;
        a_cnt   = a;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int cnt;
        repeat (3) @(negedge clk);
        // R4 outputs low during reset
        chk("R4", {31'd0, div_pulse}, 32'd0);
        chk("R4", {31'd0, cfg_err}, 32'd0);
        rst_n = 1'b1;
        cnt = 0;
        while (div_pulse !== 1'b1) begin
            @(negedge clk);
            cnt++;
        end
        chk("R4", cnt, 32'd56);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            apply(VECS[i].sel, VECS[i].b, VECS[i].a);
            @(negedge clk);
            chk("R6", {31'd0, cfg_err}, {31'd0, VECS[i].err});
            wait_pulse();
            measure(cnt);
            chk(vec_tag(i), cnt, VECS[i].n);
        end

        // R7: change mid-period, current period keeps old ratio (16)
        wait_pulse();
        cnt = 0;
        repeat (3) begin
            @(negedge clk);
            cnt++;
        end
        apply(2'd0, 13'd9, 13'd5 > 0 ? 5'd5 : 5'd0);
        while (div_pulse !== 1'b1) begin
            @(negedge clk);
            cnt++;
        end
        chk("R7", cnt, 32'd16);
        measure(cnt);
        chk("R7", cnt, 32'd77);

        // R6: flag clears after a legal setting follows an illegal one
        @(negedge clk);
        apply(2'd3, 13'd9, 5'd5);
        @(negedge clk);
        chk("R6", {31'd0, cfg_err}, 32'd1);
        apply(2'd0, 13'd9, 5'd5);
        @(negedge clk);
        chk("R6", {31'd0, cfg_err}, 32'd0);

        // R4: reset mid-run forces outputs low
        apply(2'd3, 13'd9, 5'd5);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R4", {31'd0, div_pulse}, 32'd0);
        chk("R4", {31'd0, cfg_err}, 32'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule